// File: doc/BRIEF.md
# Register Busy Vector with Dual One-Hot Write Ports

This block records which integer registers of an in-order core still wait for a result. It holds one busy bit for each of 32 registers. When the issue stage dispatches an instruction, it marks that instruction's destination registers busy. When a result is written back, the writeback logic marks the register free again.

There are two write ports, so two entries can change in the same cycle. This covers an instruction such as a load with address update, which has two destination registers. Each write port is selected by a one-hot enable vector, and each enable bit drives the strobe of its own entry, so no address decoder is needed. The issuer has the only read port, and it returns the whole vector at once.

A combinational hazard check takes the decoded operand indices of one instruction: up to three sources and two destinations, each with a valid flag. It reports whether any valid operand names a busy register. A registered error flag reports any write enable that has more than one bit set.

Top module: `regbusy_vec`

## Requirements
- R1: While `rst` is high at a rising edge, every busy bit is cleared to 0 and `onehot_err_o` is cleared to 0. Both stay cleared in the first cycle after reset is released.
- R2: A write port whose enable has exactly one bit `i` set loads its data bit into entry `i` (bit `i` of `busy_o`) at the rising edge. The new value is visible from the following cycle. Data 1 means busy and data 0 means free.
- R3: A write port whose enable is all zeros causes no change. When both enables are zero, `busy_o` holds its value.
- R4: The two ports can write different entries in the same cycle, and both updates take effect at the same edge.
- R5: When both ports select the same entry in one cycle, the entry takes the data of port 0 (`wr0_*`).
- R6: `onehot_err_o` is 1 in the cycle after any enable has two or more bits set, and 0 in the cycle after neither enable does. Every entry selected by such an enable is still written with that port's data.
- R7: `hazard_o` is 1 when any source operand whose valid flag is set names a register whose bit in `busy_o` is 1. Source `k` uses bits `[5k+4:5k]` of `src_idx` and bit `k` of `src_vld`.
- R8: Destination operands also take part in the hazard check. Destination `k` uses bits `[5k+4:5k]` of `dst_idx` and bit `k` of `dst_vld`. An operand whose valid flag is 0 never raises `hazard_o`, and with no valid operand `hazard_o` is 0.
- R9: An entry that neither port selects keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_en | input | 32 | One-hot entry select of write port 0 (the higher-priority port) |
| wr0_data | input | 1 | Bit that port 0 writes |
| wr1_en | input | 32 | One-hot entry select of write port 1 |
| wr1_data | input | 1 | Bit that port 1 writes |
| src_idx | input | 15 | Three packed 5-bit source register indices |
| src_vld | input | 3 | Valid flag for each source operand |
| dst_idx | input | 10 | Two packed 5-bit destination register indices |
| dst_vld | input | 2 | Valid flag for each destination operand |
| busy_o | output | 32 | Registered busy vector, one bit per register |
| hazard_o | output | 1 | A valid operand names a busy register |
| onehot_err_o | output | 1 | Registered flag: an enable had more than one bit set in the previous cycle |

## Verification
The assertions check the following on every cycle:
- Reset clears the vector and the error flag.
- A one-hot port 0 write lands in the selected entry with port 0 data, which also covers its priority over port 1.
- Entries that no port selects hold their value, and an idle cycle leaves the vector unchanged.
- The error flag follows the multi-hot condition one cycle later.
- `hazard_o` stays low when no operand is valid, and it is never raised while the vector is empty.

Some behaviour can only be shown by the bench's scenarios, which compare the whole vector with a model after each write:
- Two ports updating different entries in the same cycle.
- The overlap outcome in both data directions.
- Multi-hot writes that still update every selected entry.
- The exact hazard value for particular mixes of valid and invalid sources and destinations against a known busy state.

// File: rtl/regbusy_pkg.sv
package regbusy_pkg;

  // default geometry of the busy vector and of one instruction's operands
  localparam int unsigned DEF_NREG = 32;
  localparam int unsigned DEF_NSRC = 3;
  localparam int unsigned DEF_NDST = 2;
  // number of write ports; port 0 has the highest priority
  localparam int unsigned NWPORT   = 2;

  // per-entry next-state choice made by the write merge
  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_PORT0 = 2'd1,
    SEL_PORT1 = 2'd2
  } wsel_e;

  // true when a select vector has two or more bits set
  function automatic logic multi_hot(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction

endpackage

// File: rtl/regbusy_wr_merge.sv
module regbusy_wr_merge
  import regbusy_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG
) (
  input  logic [NWPORT*NREG-1:0] wen_flat,
  input  logic [NWPORT-1:0]      wdata,
  input  logic [NREG-1:0]        cur,
  output logic [NREG-1:0]        nxt,
  output logic [NREG-1:0]        strobe
);

  // Each enable bit is the strobe of its own entry. The lower port index wins.
  for (genvar e = 0; e < NREG; e++) begin : g_entry
    wsel_e sel;

    always_comb begin
      if (wen_flat[e])
        sel = SEL_PORT0;
      else if (wen_flat[NREG + e])
        sel = SEL_PORT1;
      else
        sel = SEL_HOLD;
    end

    always_comb begin
      unique case (sel)
        SEL_PORT0: nxt[e] = wdata[0];
        SEL_PORT1: nxt[e] = wdata[1];
        default:   nxt[e] = cur[e];
      endcase
    end

    assign strobe[e] = (sel != SEL_HOLD);
  end

endmodule

// File: rtl/regbusy_store.sv
module regbusy_store #(
  parameter int unsigned NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] strobe,
  input  logic [NREG-1:0] nxt,
  output logic [NREG-1:0] q
);

  // one flop per entry, loaded only when that entry's strobe is high
  for (genvar e = 0; e < NREG; e++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[e] <= 1'b0;
      else if (strobe[e])
        q[e] <= nxt[e];
    end
  end

endmodule

// File: rtl/regbusy_multihot.sv
module regbusy_multihot
  import regbusy_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWPORT*NREG-1:0] wen_flat,
  output logic                   err_q
);

  logic [NWPORT-1:0] bad;

  for (genvar p = 0; p < NWPORT; p++) begin : g_port
    logic [63:0] widened;
    assign widened = 64'(wen_flat[p*NREG +: NREG]);
    assign bad[p]  = multi_hot(widened);
  end

  always_ff @(posedge clk) begin
    if (rst)
      err_q <= 1'b0;
    else
      err_q <= |bad;
  end

endmodule

// File: rtl/regbusy_hazard.sv
module regbusy_hazard #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NOPS = 5,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0]      busy,
  input  logic [NOPS*IDXW-1:0] op_idx,
  input  logic [NOPS-1:0]      op_vld,
  output logic                 hazard
);

  logic [NOPS-1:0] hit;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [IDXW-1:0] idx;
    logic            in_range;
    assign idx      = op_idx[k*IDXW +: IDXW];
    assign in_range = (32'(idx) < NREG);
    assign hit[k]   = op_vld[k] && in_range && busy[idx];
  end

  assign hazard = |hit;

endmodule

// File: rtl/regbusy_vec.sv
module regbusy_vec
  import regbusy_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned NSRC = DEF_NSRC,
  parameter int unsigned NDST = DEF_NDST,
  localparam int unsigned IDXW = $clog2(NREG),
  localparam int unsigned NOPS = NSRC + NDST
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREG-1:0]      wr0_en,
  input  logic                 wr0_data,
  input  logic [NREG-1:0]      wr1_en,
  input  logic                 wr1_data,
  input  logic [NSRC*IDXW-1:0] src_idx,
  input  logic [NSRC-1:0]      src_vld,
  input  logic [NDST*IDXW-1:0] dst_idx,
  input  logic [NDST-1:0]      dst_vld,
  output logic [NREG-1:0]      busy_o,
  output logic                 hazard_o,
  output logic                 onehot_err_o
);

  logic [NWPORT*NREG-1:0] wen_flat;
  logic [NWPORT-1:0]      wdata;
  logic [NREG-1:0]        nxt;
  logic [NREG-1:0]        strobe;

  assign wen_flat = {wr1_en, wr0_en};
  assign wdata    = {wr1_data, wr0_data};

  regbusy_wr_merge #(.NREG(NREG)) u_merge (
    .wen_flat (wen_flat),
    .wdata    (wdata),
    .cur      (busy_o),
    .nxt      (nxt),
    .strobe   (strobe)
  );

  regbusy_store #(.NREG(NREG)) u_store (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .nxt    (nxt),
    .q      (busy_o)
  );

  regbusy_multihot #(.NREG(NREG)) u_mhot (
    .clk      (clk),
    .rst      (rst),
    .wen_flat (wen_flat),
    .err_q    (onehot_err_o)
  );

  regbusy_hazard #(.NREG(NREG), .NOPS(NOPS)) u_haz (
    .busy   (busy_o),
    .op_idx ({dst_idx, src_idx}),
    .op_vld ({dst_vld, src_vld}),
    .hazard (hazard_o)
  );

endmodule

// File: rtl/regbusy_vec_chk.sv
module regbusy_vec_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NSRC = 3,
  parameter int unsigned NDST = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] wr0_en,
  input logic            wr0_data,
  input logic [NREG-1:0] wr1_en,
  input logic            wr1_data,
  input logic [NSRC-1:0] src_vld,
  input logic [NDST-1:0] dst_vld,
  input logic [NREG-1:0] busy_o,
  input logic            hazard_o,
  input logic            onehot_err_o
);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (busy_o == '0) && !onehot_err_o);

  // R2 R5
  port0_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr0_en) == 1) |=>
      ((busy_o & $past(wr0_en)) == ($past(wr0_data) ? $past(wr0_en) : '0)));

  // R2
  port1_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr1_en) == 1 && wr0_en == '0) |=>
      ((busy_o & $past(wr1_en)) == ($past(wr1_data) ? $past(wr1_en) : '0)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr0_en == '0 && wr1_en == '0) |=> $stable(busy_o));

  // R9
  unselected_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((busy_o ^ $past(busy_o)) & ~($past(wr0_en) | $past(wr1_en))) == '0));

  // R6
  multihot_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr0_en) > 1 || $countones(wr1_en) > 1) |=> onehot_err_o);

  // R6
  onehot_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr0_en) <= 1 && $countones(wr1_en) <= 1) |=> !onehot_err_o);

  // R8
  no_valid_no_hazard_chk: assert property (@(posedge clk) disable iff (rst)
    (src_vld == '0 && dst_vld == '0) |-> !hazard_o);

  // R7
  empty_no_hazard_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o == '0) |-> !hazard_o);

endmodule

bind regbusy_vec regbusy_vec_chk #(.NREG(NREG), .NSRC(NSRC), .NDST(NDST)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr0_en       (wr0_en),
  .wr0_data     (wr0_data),
  .wr1_en       (wr1_en),
  .wr1_data     (wr1_data),
  .src_vld      (src_vld),
  .dst_vld      (dst_vld),
  .busy_o       (busy_o),
  .hazard_o     (hazard_o),
  .onehot_err_o (onehot_err_o)
);

// File: tb/regbusy_vec_tb.sv
`timescale 1ns/1ps
module regbusy_vec_tb;

  localparam int NREG = 32;
  localparam int NSRC = 3;
  localparam int NDST = 2;
  localparam int IDXW = 5;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NREG-1:0]      wr0_en = '0;
  logic                 wr0_data = 1'b0;
  logic [NREG-1:0]      wr1_en = '0;
  logic                 wr1_data = 1'b0;
  logic [NSRC*IDXW-1:0] src_idx = '0;
  logic [NSRC-1:0]      src_vld = '0;
  logic [NDST*IDXW-1:0] dst_idx = '0;
  logic [NDST-1:0]      dst_vld = '0;
  logic [NREG-1:0]      busy_o;
  logic                 hazard_o;
  logic                 onehot_err_o;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  typedef struct {
    logic [NREG-1:0] vec;
    logic            err;
    string           tag;
  } exp_t;

  exp_t            sb_q[$];
  logic [NREG-1:0] model = '0;

  regbusy_vec u_dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  // monitor: compares each expected item 1 ns after the edge it belongs to
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (busy_o !== e.vec || onehot_err_o !== e.err) begin
        fails++;
        $display("FAIL %s: busy=%h err=%b expected busy=%h err=%b",
                 e.tag, busy_o, onehot_err_o, e.vec, e.err);
      end
    end
  end

  function automatic int popc(input logic [NREG-1:0] v);
    int n = 0;
    for (int i = 0; i < NREG; i++) n += int'(v[i]);
    return n;
  endfunction

  // driver: inputs change 2 ns after an edge; the expected item is queued for the next edge
  task automatic drive_wr(input logic [NREG-1:0] e0, input logic d0,
                          input logic [NREG-1:0] e1, input logic d1,
                          input string tag);
    exp_t item;
    wr0_en = e0; wr0_data = d0; wr1_en = e1; wr1_data = d1;
    for (int i = 0; i < NREG; i++) begin
      if (e0[i])      model[i] = d0;
      else if (e1[i]) model[i] = d1;
    end
    item.vec = model;
    item.err = (popc(e0) > 1) || (popc(e1) > 1);
    item.tag = tag;
    sb_q.push_back(item);
    @(posedge clk);
    #2;
    wr0_en = '0; wr1_en = '0; wr0_data = 1'b0; wr1_data = 1'b0;
  endtask

  task automatic check_haz(input logic [4:0] s0, input logic [4:0] s1, input logic [4:0] s2,
                           input logic [NSRC-1:0] sv,
                           input logic [4:0] t0, input logic [4:0] t1,
                           input logic [NDST-1:0] tv, input string tag);
    logic expv;
    src_idx = {s2, s1, s0}; src_vld = sv;
    dst_idx = {t1, t0};     dst_vld = tv;
    expv = (sv[0] & model[s0]) | (sv[1] & model[s1]) | (sv[2] & model[s2]) |
           (tv[0] & model[t0]) | (tv[1] & model[t1]);
    #1;
    checks++;
    if (hazard_o !== expv) begin
      fails++;
      $display("FAIL %s: hazard=%b expected %b", tag, hazard_o, expv);
    end
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    #1;
    checks++;  // R1 reset state
    if (busy_o !== '0 || onehot_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: busy=%h err=%b expected busy=0 err=0", busy_o, onehot_err_o);
    end
    @(posedge clk); #2;

    drive_wr(32'h1 << 5, 1'b1, '0, 1'b0, "R2 set entry 5 via port 0");
    drive_wr('0, 1'b1, '0, 1'b1, "R3 zero enables hold");
    drive_wr(32'h1 << 7, 1'b1, 32'h1 << 20, 1'b1, "R4 dual set 7 and 20");
    drive_wr(32'h1 << 31, 1'b1, 32'h1 << 5, 1'b0, "R4 set 31 and clear 5");
    drive_wr(32'h1 << 7, 1'b0, 32'h1 << 7, 1'b1, "R5 overlap port0 clear wins");
    drive_wr(32'h1, 1'b1, 32'h1, 1'b0, "R5 overlap port0 set wins");
    drive_wr('0, 1'b0, 32'h3 << 10, 1'b1, "R6 multi-hot flag and write");
    drive_wr('0, 1'b0, '0, 1'b0, "R6 flag clears, R9 hold");
    drive_wr(32'h1 << 12, 1'b1, '0, 1'b0, "R9 others hold");
    @(posedge clk); #2;

    // busy now {0,10,11,12,20,31}
    check_haz(5'd20, 5'd31, 5'd0, 3'b000, 5'd10, 5'd11, 2'b00, "R8 no valid operands");
    check_haz(5'd1, 5'd2, 5'd3, 3'b111, 5'd4, 5'd5, 2'b00, "R7 free sources");
    check_haz(5'd1, 5'd2, 5'd20, 3'b111, 5'd4, 5'd5, 2'b00, "R7 busy third source");
    check_haz(5'd1, 5'd2, 5'd3, 3'b011, 5'd4, 5'd31, 2'b10, "R8 busy second destination");
    check_haz(5'd1, 5'd2, 5'd3, 3'b111, 5'd11, 5'd31, 2'b00, "R8 invalid destinations ignored");
    check_haz(5'd0, 5'd2, 5'd3, 3'b001, 5'd4, 5'd5, 2'b11, "R7 busy first source");

    // issue then writeback cycle
    drive_wr(32'h1 << 3, 1'b1, 32'h1 << 4, 1'b1, "R4 issue sets two destinations");
    check_haz(5'd1, 5'd2, 5'd3, 3'b100, 5'd0, 5'd0, 2'b00, "R7 source now busy");
    drive_wr(32'h1 << 3, 1'b0, 32'h1 << 4, 1'b0, "R2 writeback clears");
    @(posedge clk); #2;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule